// File: doc/BRIEF.md
# Sampling Tap Window Selector

This block picks a receive sampling clock tap once a tuning sweep has finished. The sweep probes every physical tap twice, so the block receives a pass/fail vector of 2*N bits, where N is the number of physical taps. Bit i is 1 when probe i passed. Bits N..2N-1 repeat the taps in the same order, which lets a window of passing taps that wraps past the last tap appear as one unbroken run.

A single-cycle start pulse captures the vector. The block then walks it one index per clock and keeps the longest run of consecutive passing probes. If that run holds at least three probes, the block folds the run's centre back into the range 0..N-1. It drives the folded value on the tap output and pulses done together with an auto re-tune enable strobe. If no run is long enough, it pulses an error and leaves the tap output as it was. Issuing the probe commands and moving the clock phase are handled elsewhere.

Top module: `tap_window_sel`

## Requirements
- R1: When idle, a start pulse captures pass_vec and raises busy in the next cycle. Later changes on pass_vec have no effect on that scan. Exactly one of done or err is high in the cycle that comes 2*N+2 clock edges after the edge that sampled start.
- R2: The block finds the longest run of consecutive 1 bits in the captured vector, scanning from index 0 up to index 2*N-1. A run replaces the recorded best only when it is strictly longer, so of two equal runs the one at the lower index wins.
- R3: A run that is still open at index 2*N-1 is compared under the same strict rule, as if a fail bit stood at index 2*N.
- R4: Let k be the index that ends the best run and L its length. The run's first index is k-L and its last index is k-1. The tap output becomes ((first+last)/2) mod N, using integer division, and it always stays below N.
- R5: If the best run holds fewer than 3 probes, err pulses for one cycle. In that case done and retune_en stay low and tap_sel keeps its previous value.
- R6: If the best run holds 3 or more probes, done and retune_en pulse high together for exactly one cycle, and tap_sel carries the new tap in that same cycle.
- R7: A start pulse that arrives while busy is high is ignored. The scan already running keeps its vector and its timing.
- R8: done and err are never high in the same cycle, and neither stays high for two cycles in a row.
- R9: After reset, busy, done, err and retune_en are 0 and tap_sel is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch pulse, acted on only when idle |
| pass_vec | input | 2*NUM_TAPS | Probe results; bit i is probe i, 1 means pass |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse: a tap was chosen |
| err | output | 1 | One-cycle pulse: no window of at least 3 probes |
| retune_en | output | 1 | One-cycle auto re-tune enable strobe, raised together with done |
| tap_sel | output | $clog2(NUM_TAPS) | Selected physical tap |

## Verification
Some properties are checked on every cycle: done and err never coincide and never last two cycles; retune_en moves only together with done; tap_sel is held across an error and stays below N; and every result appears exactly 2*N+2 edges after the start that launched it, measured by a counter in the checker. Other properties can only be shown by the bench's scenarios: that the chosen tap is the correct folded centre, that equal runs resolve to the earliest one, that a run open at the end of the vector is counted, and that the captured vector ignores later input changes and mid-scan starts. The bench sweeps every 8-bit pattern on a 4-tap instance and every 6-bit pattern on a 3-tap instance, which covers both the power-of-two fold and the subtracting fold.

// File: rtl/tws_pkg.sv
// Shared definitions for the sampling tap window selector.
// Assumes nothing beyond IEEE 1800-2017 packages.
package tws_pkg;
    // Sequencer states.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_CLOSE  = 2'd2,
        ST_DECIDE = 2'd3
    } tws_state_e;

    // Shortest passing window that is accepted.
    localparam int MIN_WINDOW = 3;
endpackage

// File: rtl/tws_ctrl.sv
// Sequencer: captures the probe vector on an accepted start, then shifts
// it out one bit per clock while counting the index. After the last
// index it spends one cycle closing the tail run and one cycle deciding.
// Assumes start is ignored unless the sequencer is idle.
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int NUM_TAPS = 8,
    parameter int VW       = 2 * NUM_TAPS,
    parameter int IW       = $clog2(VW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] pass_vec,
    output logic          clear,
    output logic          step,
    output logic          close,
    output logic          decide,
    output logic          pass_bit,
    output logic [IW-1:0] idx,
    output logic          busy
);
    localparam logic [IW-1:0] LAST_IDX = IW'(VW - 1);

    tws_state_e    state_q;
    logic [VW-1:0] vec_q;

    // State, index counter and probe shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx     <= '0;
            vec_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        vec_q   <= pass_vec;
                        idx     <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    vec_q <= vec_q >> 1;
                    idx   <= idx + 1'b1;
                    if (idx == LAST_IDX) state_q <= ST_CLOSE;
                end
                ST_CLOSE:  state_q <= ST_DECIDE;
                default:   state_q <= ST_IDLE;
            endcase
        end
    end

    // Per-state strobes for the datapath.
    always_comb begin
        clear    = (state_q == ST_IDLE) && start;
        step     = (state_q == ST_SCAN);
        close    = (state_q == ST_CLOSE);
        decide   = (state_q == ST_DECIDE);
        busy     = (state_q != ST_IDLE);
        pass_bit = vec_q[0];
    end
endmodule

// File: rtl/tws_run_tracker.sv
// Longest-run tracker. Counts consecutive pass bits. When a fail bit or
// the close strobe ends a run, the run replaces the best record only if
// it is strictly longer. The record holds the run's first and last index.
// Assumes idx equals 2N while close is high.
module tws_run_tracker #(
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic          pass_bit,
    input  logic          close,
    input  logic [IW-1:0] idx,
    output logic [IW-1:0] best_len,
    output logic [IW-1:0] best_first,
    output logic [IW-1:0] best_last
);
    logic [IW-1:0] run_q;
    logic          run_ends;

    // A run ends on a fail bit during the scan, or at the close step.
    always_comb run_ends = (step && !pass_bit) || close;

    // Running count and best-run record.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            run_q      <= '0;
            best_len   <= '0;
            best_first <= '0;
            best_last  <= '0;
        end else if (step && pass_bit) begin
            run_q <= run_q + 1'b1;
        end else if (run_ends) begin
            if (run_q > best_len) begin
                best_len   <= run_q;
                best_first <= idx - run_q;
                best_last  <= idx - 1'b1;
            end
            run_q <= '0;
        end
    end
endmodule

// File: rtl/tws_tap_fold.sv
// Centre-and-fold: (first + last) / 2, reduced modulo NUM_TAPS. The
// centre is always below 2*NUM_TAPS, so one conditional subtraction is
// enough. A power-of-two tap count needs only the low bits.
module tws_tap_fold #(
    parameter int NUM_TAPS = 8,
    parameter int IW       = 5,
    parameter int TW       = $clog2(NUM_TAPS)
) (
    input  logic [IW-1:0] first,
    input  logic [IW-1:0] last,
    output logic [TW-1:0] tap
);
    localparam logic [IW-1:0] N_IW = IW'(NUM_TAPS);

    logic [IW:0]   sum;
    logic [IW-1:0] centre;

    // Midpoint with integer division.
    always_comb begin
        sum    = {1'b0, first} + {1'b0, last};
        centre = IW'(sum >> 1);
    end

    generate
        if ((NUM_TAPS & (NUM_TAPS - 1)) == 0) begin : g_pow2
            // Modulo by truncation.
            always_comb tap = TW'(centre);
        end else begin : g_sub
            logic [IW-1:0] folded;
            // Modulo by a single conditional subtraction.
            always_comb begin
                folded = (centre >= N_IW) ? centre - N_IW : centre;
                tap    = TW'(folded);
            end
        end
    endgenerate
endmodule

// File: rtl/tap_window_sel.sv
// Sampling tap window selector top. Ties the sequencer, the run tracker
// and the fold together and registers the result strobes and the tap.
// Assumes NUM_TAPS is between 2 and 16.
module tap_window_sel
    import tws_pkg::*;
#(
    parameter int NUM_TAPS = 8,
    parameter int VW       = 2 * NUM_TAPS,
    parameter int IW       = $clog2(VW + 1),
    parameter int TW       = $clog2(NUM_TAPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [VW-1:0] pass_vec,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic          retune_en,
    output logic [TW-1:0] tap_sel
);
    localparam logic [IW-1:0] MIN_LEN = IW'(MIN_WINDOW);

    logic          clear, step, close, decide, pass_bit;
    logic [IW-1:0] idx, best_len, best_first, best_last;
    logic [TW-1:0] folded_tap;

    tws_ctrl #(.NUM_TAPS(NUM_TAPS), .VW(VW), .IW(IW)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pass_vec(pass_vec),
        .clear(clear), .step(step), .close(close), .decide(decide),
        .pass_bit(pass_bit), .idx(idx), .busy(busy)
    );

    tws_run_tracker #(.IW(IW)) track_i (
        .clk(clk), .rst_n(rst_n), .clear(clear), .step(step),
        .pass_bit(pass_bit), .close(close), .idx(idx),
        .best_len(best_len), .best_first(best_first), .best_last(best_last)
    );

    tws_tap_fold #(.NUM_TAPS(NUM_TAPS), .IW(IW), .TW(TW)) fold_i (
        .first(best_first), .last(best_last), .tap(folded_tap)
    );

    // Result strobes and tap register, updated only in the decide cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done      <= 1'b0;
            err       <= 1'b0;
            retune_en <= 1'b0;
            tap_sel   <= '0;
        end else begin
            done      <= 1'b0;
            err       <= 1'b0;
            retune_en <= 1'b0;
            if (decide) begin
                if (best_len >= MIN_LEN) begin
                    done      <= 1'b1;
                    retune_en <= 1'b1;
                    tap_sel   <= folded_tap;
                end else begin
                    err <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tws_checker.sv
// Protocol checker for tap_window_sel, attached with bind. It counts the
// cycles since an accepted start and checks result timing, strobe
// exclusivity and that the tap is held on an error.
module tws_checker #(
    parameter int NUM_TAPS = 8,
    parameter int TW       = $clog2(NUM_TAPS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic          retune_en,
    input logic [TW-1:0] tap_sel
);
    localparam logic [7:0] LAT = 8'(2 * NUM_TAPS + 3);

    logic [7:0] since_q;

    // Cycles elapsed since the start that launched the current scan.
    always_ff @(posedge clk) begin
        if (!rst_n)                since_q <= '0;
        else if (start && !busy)   since_q <= 8'd1;
        else if (done || err)      since_q <= '0;
        else if (since_q != 8'd0)  since_q <= since_q + 8'd1;
    end

    a_r1_start_launch: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    a_r1_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> (since_q == LAT));
    a_r7_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && since_q != LAT - 8'd1) |=> busy);
    a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
    a_r6_retune_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> retune_en);
    a_r5_no_retune_alone: assert property (@(posedge clk) disable iff (!rst_n)
        retune_en |-> done);
    a_r5_tap_held_on_err: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $stable(tap_sel));
    a_r4_tap_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tap_sel) < NUM_TAPS);
endmodule

bind tap_window_sel tws_checker #(.NUM_TAPS(NUM_TAPS), .TW(TW)) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .retune_en(retune_en), .tap_sel(tap_sel)
);

// File: tb/tap_window_sel_tb_top.sv
// Bench: every 8-bit pattern on a 4-tap instance and every 6-bit pattern
// on a 3-tap instance, with and without a start pulse in mid-scan.
module tap_window_sel_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [7:0] vec4 = '0;
    logic [5:0] vec3 = '0;
    logic busy4, done4, err4, ret4, busy3, done3, err3, ret3;
    logic [1:0] tap4, tap3;
    int checks = 0, errors = 0;
    int last4 = 0, last3 = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    tap_window_sel #(.NUM_TAPS(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pass_vec(vec4),
        .busy(busy4), .done(done4), .err(err4), .retune_en(ret4), .tap_sel(tap4));
    tap_window_sel #(.NUM_TAPS(3)) dut_b_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pass_vec(vec3),
        .busy(busy3), .done(done3), .err(err3), .retune_en(ret3), .tap_sel(tap3));

    task automatic check(input bit cond, input string req, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected result taken directly from the requirements.
    task automatic model(input logic [7:0] v, input int n, output bit ok, output int tap);
        int run = 0, best = 0, bs = 0, be = 0;
        for (int i = 0; i <= 2 * n; i++) begin
            if (i < 2 * n && v[i]) run++;
            else begin
                if (run > best) begin bs = i - run; be = i - 1; best = run; end
                run = 0;
            end
        end
        ok  = (best >= 3);
        tap = ((bs + be) / 2) % n;
    endtask

    task automatic check_result(input int n, input logic [7:0] v, input logic d,
                                input logic e, input logic r, input int tap, inout int last);
        bit ok;
        int et;
        model(v, n, ok, et);
        if (ok) begin
            check(d && !e, "R6 done", {d, e}, 2);
            check(r, "R6 retune_en", r, 1);
            check(tap == et, "R4 tap", tap, et);
            last = et;
        end else begin
            check(e && !d, "R5 err", {d, e}, 1);
            check(!r, "R5 retune_en", r, 0);
            check(tap == last, "R5 tap held", tap, last);
        end
    endtask

    task automatic run_case(input logic [7:0] pat, input bit mid_start);
        @(negedge clk);
        vec4 = pat; vec3 = pat[5:0]; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(busy4 && busy3, "R1 busy", {busy4, busy3}, 3);
        for (int c = 1; c <= 10; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (c == 1) begin vec4 = ~pat; vec3 = ~pat[5:0]; end
            if (mid_start && c == 3) start = 1'b1;   // R7 ignored restart
            if (c == 4) start = 1'b0;
            if (c == 8) check_result(3, {2'b00, pat[5:0]}, done3, err3, ret3, int'(tap3), last3);
            else if (done3 || err3) check(1'b0, "R1 timing n3", c, 8);
            if (c == 10) check_result(4, pat, done4, err4, ret4, int'(tap4), last4);
            else if (done4 || err4) check(1'b0, "R1 timing n4", c, 10);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9 reset state
        check(!busy4 && !done4 && !err4 && !ret4 && tap4 == 0, "R9 n4", {busy4, done4, err4, ret4}, 0);
        check(!busy3 && !done3 && !err3 && !ret3 && tap3 == 0, "R9 n3", {busy3, done3, err3, ret3}, 0);
        // R2 equal runs at 0..2 and 5..7: earliest wins, tap 1
        run_case(8'b1110_0111, 1'b0);
        check(int'(tap4) == 1, "R2 tie keeps earliest", int'(tap4), 1);
        // R3 tail run 4..7 counted, centre 5 folds to 1
        run_case(8'b1111_0000, 1'b0);
        check(int'(tap4) == 1, "R3 open tail", int'(tap4), 1);
        // R5 short windows only: tap stays 1
        run_case(8'b0110_1101, 1'b0);
        check(int'(tap4) == 1 && err4, "R5 reject short", int'(tap4), 1);
        for (int p = 0; p < 256; p++) run_case(8'(p), 1'b0);
        for (int p = 0; p < 256; p++) run_case(8'(p), 1'b1);   // R7
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule